// File: doc/BRIEF.md
# Vector Packet Execution Reorderer

This block takes a decoded packet of up to `N_ENTRIES` instructions and puts it into the order in which vector memory operations must execute. Each entry carries a set of attribute flags and an opaque payload. The flags mark an entry as vector, load, store, new-value, temporary, scatter-release, four-slot or end-of-loop. The payload holds the opcode, register fields and slot, and it moves together with its entry.

A request is a pulse on `start_i`. The block then runs a short sequence of passes and performs at most one move per clock. In the first pass, vector producers are pushed behind a load that consumes a freshly loaded value. In the second pass, one new-value vector store is pushed to the end. An end-of-loop entry in the last position is never displaced. Finally the block reports where the first four-slot vector instruction sits. When the result is ready, `done_o` pulses for one cycle. The reordered packet stays on the outputs until the next request.

Top module: `vec_pkt_reorder`

## Requirements
- R1: While and after reset, `done_o` and `flag_valid_o` are 0 and `src_idx_o` reads the identity order: position p holds p. Position p of `src_idx_o` is bits [p*IDX_W +: IDX_W], and `payload_o` uses the same per-position layout.
- R2: Pass one locates the lowest-indexed entry below `count_i` that is a load with the new-value or temporary flag. Every vector entry found before it is moved toward the end. A move takes out the entry at index i, slides the entries after it down by one and places the entry at the target position. The same index i is then examined again and the scan limit drops by one.
- R3: The target of every move is position `count_i`-1. When the entry there has the end-of-loop flag, the target is `count_i`-2 instead, so the end-of-loop entry stays last.
- R4: Pass two looks at positions 0 to `count_i`-2 only. It takes the first store that has the new-value flag and lacks the scatter-release flag, moves that single entry to the target of R3, and moves nothing else.
- R5: When `disas_only_i` is 1 at the start pulse, no entry moves and the output order equals the input order.
- R6: `flag_idx_o` gives the lowest position, in the final order and below `count_i`, of an entry carrying both the vector and four-slot flags. `flag_valid_o` is 1 when such an entry exists and 0 otherwise. This holds in both modes.
- R7: Each payload leaves at the same position as its source index, so `src_idx_o` is always a permutation. Positions at or above `count_i` keep their input entries.
- R8: `done_o` is high for exactly one cycle per request, within 2*`N_ENTRIES`+4 cycles of the start pulse. The outputs then hold steady until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; captures the packet when idle |
| disas_only_i | input | 1 | Skip both reorder passes |
| count_i | input | CNT_W | Number of valid entries, 1..N_ENTRIES |
| vec_i | input | N_ENTRIES | Vector flag per entry |
| load_i | input | N_ENTRIES | Load flag per entry |
| store_i | input | N_ENTRIES | Store flag per entry |
| newval_i | input | N_ENTRIES | New-value flag per entry |
| tmp_i | input | N_ENTRIES | Temporary flag per entry |
| scat_rel_i | input | N_ENTRIES | Scatter-release flag per entry |
| four_slot_i | input | N_ENTRIES | Four-slot flag per entry |
| endloop_i | input | N_ENTRIES | End-of-loop flag per entry (any loop variant) |
| payload_i | input | N_ENTRIES*PAYLOAD_W | Payload per entry |
| done_o | output | 1 | Result ready, one-cycle pulse |
| payload_o | output | N_ENTRIES*PAYLOAD_W | Reordered payloads |
| src_idx_o | output | N_ENTRIES*IDX_W | Input index of the entry at each position |
| flag_valid_o | output | 1 | A four-slot vector entry exists |
| flag_idx_o | output | IDX_W | Position of the first four-slot vector entry |

## Verification
The bench uses the default `N_ENTRIES`=4 and `PAYLOAD_W`=8. With four entries, every packet length from one to four can be reached within a few thousand requests. The sweep also covers back-to-back vector moves that re-examine the same index, special loads at any position, end-of-loop pinning and store selection at the scan edge. Expected order, payloads and flag position come from a behavioural reorder model in the bench. Directed packets pin down the move sequences, the end-of-loop target, the excluded last position and the disassembly bypass.

// File: rtl/vpr_pkg.sv
`timescale 1ns/1ps
package vpr_pkg;
  typedef struct packed {
    logic vec;
    logic ld;
    logic st;
    logic nv;
    logic tmp;
    logic srel;
    logic four;
    logic eloop;
  } attr_t;

  localparam int ATTR_W = $bits(attr_t);

  typedef enum logic [2:0] {
    ST_IDLE, ST_P1_FIND, ST_P1_MOVE, ST_P2, ST_FLAG, ST_DONE
  } state_e;
endpackage

// File: rtl/vpr_first_hit.sv
`timescale 1ns/1ps
module vpr_first_hit #(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  output logic                 found_o,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = N_ENTRIES - 1; k >= 0; k--) begin
      if (hit_i[k]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/vpr_rotate.sv
`timescale 1ns/1ps
module vpr_rotate #(
  parameter int N_ENTRIES = 4,
  parameter int EW        = 18,
  parameter int IDX_W     = 2
) (
  input  logic [N_ENTRIES-1:0][EW-1:0] ent_i,
  input  logic [IDX_W-1:0]             from_i,
  input  logic [IDX_W-1:0]             to_i,
  output logic [N_ENTRIES-1:0][EW-1:0] ent_o
);
  // from_i >= to_i leaves the array untouched
  always_comb begin
    for (int k = 0; k < N_ENTRIES; k++) begin
      if (IDX_W'(k) < from_i || IDX_W'(k) > to_i) ent_o[k] = ent_i[k];
      else if (IDX_W'(k) == to_i)                 ent_o[k] = ent_i[from_i];
      else                                        ent_o[k] = ent_i[(k == N_ENTRIES - 1) ? k : k + 1];
    end
  end
endmodule

// File: rtl/vec_pkt_reorder.sv
`timescale 1ns/1ps
module vec_pkt_reorder
  import vpr_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int PAYLOAD_W = 8,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CNT_W    = $clog2(N_ENTRIES + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           disas_only_i,
  input  logic [CNT_W-1:0]               count_i,
  input  logic [N_ENTRIES-1:0]           vec_i,
  input  logic [N_ENTRIES-1:0]           load_i,
  input  logic [N_ENTRIES-1:0]           store_i,
  input  logic [N_ENTRIES-1:0]           newval_i,
  input  logic [N_ENTRIES-1:0]           tmp_i,
  input  logic [N_ENTRIES-1:0]           scat_rel_i,
  input  logic [N_ENTRIES-1:0]           four_slot_i,
  input  logic [N_ENTRIES-1:0]           endloop_i,
  input  logic [N_ENTRIES*PAYLOAD_W-1:0] payload_i,
  output logic                           done_o,
  output logic [N_ENTRIES*PAYLOAD_W-1:0] payload_o,
  output logic [N_ENTRIES*IDX_W-1:0]     src_idx_o,
  output logic                           flag_valid_o,
  output logic [IDX_W-1:0]               flag_idx_o
);
  localparam int EW = ATTR_W + IDX_W + PAYLOAD_W;
  typedef logic [N_ENTRIES-1:0][EW-1:0] ent_arr_t;

  state_e           state_q;
  ent_arr_t         ent_q, ent_in, ent_rot;
  logic [CNT_W-1:0] cnt_q, cnt_m1;
  logic [IDX_W-1:0] i_q, max_q, last_idx, tgt_idx, from_idx;
  logic [IDX_W-1:0] ld_idx, st_idx, fl_idx;
  logic             ld_found, st_found, fl_found;
  logic             flag_valid_q;
  logic [IDX_W-1:0] flag_idx_q;
  logic             busy;
  attr_t            a [N_ENTRIES];
  logic [N_ENTRIES-1:0] ld_hit, st_hit, fl_hit;

  assign cnt_m1   = cnt_q - CNT_W'(1);
  assign last_idx = cnt_m1[IDX_W-1:0];
  assign tgt_idx  = a[last_idx].eloop ? last_idx - IDX_W'(1) : last_idx;
  assign from_idx = (state_q == ST_P2) ? st_idx : i_q;
  assign busy     = (state_q != ST_IDLE);

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_ent
    assign a[k] = attr_t'(ent_q[k][EW-1 -: ATTR_W]);
    assign ent_in[k] = {vec_i[k], load_i[k], store_i[k], newval_i[k], tmp_i[k],
                        scat_rel_i[k], four_slot_i[k], endloop_i[k],
                        IDX_W'(k), payload_i[k*PAYLOAD_W +: PAYLOAD_W]};
    assign ld_hit[k] = (CNT_W'(k) < cnt_q) && a[k].ld && (a[k].nv || a[k].tmp);
    assign st_hit[k] = (CNT_W'(k) < cnt_m1) && a[k].st && a[k].nv && !a[k].srel;
    assign fl_hit[k] = (CNT_W'(k) < cnt_q) && a[k].vec && a[k].four;
    assign payload_o[k*PAYLOAD_W +: PAYLOAD_W] = ent_q[k][PAYLOAD_W-1:0];
    assign src_idx_o[k*IDX_W +: IDX_W]         = ent_q[k][PAYLOAD_W +: IDX_W];
  end

  vpr_first_hit #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_ld_hit (
    .hit_i(ld_hit), .found_o(ld_found), .idx_o(ld_idx));
  vpr_first_hit #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_st_hit (
    .hit_i(st_hit), .found_o(st_found), .idx_o(st_idx));
  vpr_first_hit #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) i_fl_hit (
    .hit_i(fl_hit), .found_o(fl_found), .idx_o(fl_idx));

  vpr_rotate #(.N_ENTRIES(N_ENTRIES), .EW(EW), .IDX_W(IDX_W)) i_rotate (
    .ent_i(ent_q), .from_i(from_idx), .to_i(tgt_idx), .ent_o(ent_rot));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      i_q          <= '0;
      max_q        <= '0;
      flag_valid_q <= 1'b0;
      flag_idx_q   <= '0;
      for (int k = 0; k < N_ENTRIES; k++) ent_q[k] <= {ATTR_W'(0), IDX_W'(k), PAYLOAD_W'(0)};
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ent_q   <= ent_in;
          cnt_q   <= count_i;
          state_q <= disas_only_i ? ST_FLAG : ST_P1_FIND;
        end
        ST_P1_FIND: begin
          i_q     <= '0;
          max_q   <= ld_idx;
          state_q <= ld_found ? ST_P1_MOVE : ST_P2;
        end
        ST_P1_MOVE: begin
          if (i_q >= max_q) begin
            state_q <= ST_P2;
          end else if (a[i_q].vec) begin
            ent_q <= ent_rot;             // re-examine same index
            max_q <= max_q - IDX_W'(1);
          end else begin
            i_q <= i_q + IDX_W'(1);
          end
        end
        ST_P2: begin
          if (st_found) ent_q <= ent_rot;
          state_q <= ST_FLAG;
        end
        ST_FLAG: begin
          flag_valid_q <= fl_found;
          flag_idx_q   <= fl_idx;
          state_q      <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o       = (state_q == ST_DONE);
  assign flag_valid_o = flag_valid_q;
  assign flag_idx_o   = flag_idx_q;
endmodule

// File: rtl/vpr_checker.sv
`timescale 1ns/1ps
module vpr_checker #(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       done_o,
  input logic                       busy,
  input logic                       flag_valid_o,
  input logic [IDX_W-1:0]           flag_idx_o,
  input logic [CNT_W-1:0]           count_q,
  input logic [N_ENTRIES*IDX_W-1:0] src_idx_o
);
  localparam int LAT_MAX = 2 * N_ENTRIES + 4;

  logic [N_ENTRIES-1:0] seen;
  logic [7:0]           lat_q;

  always_comb begin
    seen = '0;
    for (int k = 0; k < N_ENTRIES; k++) seen[src_idx_o[k*IDX_W +: IDX_W]] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lat_q <= '0;
    else if (busy) lat_q <= lat_q + 8'd1;
    else           lat_q <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (lat_q <= 8'(LAT_MAX))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && $past(!busy)) |-> ($stable(src_idx_o) && $stable(flag_valid_o))); // R8
  AST_FLAG_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_valid_o) |-> (CNT_W'(flag_idx_o) < count_q)); // R6
  AST_SRC_PERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(seen) == N_ENTRIES); // R7
endmodule

bind vec_pkt_reorder vpr_checker #(
  .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) i_vpr_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .busy(busy),
  .flag_valid_o(flag_valid_o), .flag_idx_o(flag_idx_o),
  .count_q(cnt_q), .src_idx_o(src_idx_o)
);

// File: tb/test_vec_pkt_reorder.sv
`timescale 1ns/1ps
module test_vec_pkt_reorder;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int IW = 2;
  localparam int CW = 3;
  // attribute byte per entry: bit7 vec, 6 load, 5 store, 4 newval, 3 tmp, 2 scat_rel, 1 four_slot, 0 endloop
  localparam int A_VEC = 7, A_LD = 6, A_ST = 5, A_NV = 4, A_TMP = 3, A_SR = 2, A_FOUR = 1, A_EL = 0;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, disas = 0;
  logic [CW-1:0] count = '0;
  logic [N-1:0] vec_v = '0, ld_v = '0, st_v = '0, nv_v = '0, tmp_v = '0, sr_v = '0, four_v = '0, el_v = '0;
  logic [N*PW-1:0] pl_in = '0;
  logic done;
  logic [N*PW-1:0] pl_out;
  logic [N*IW-1:0] src_out;
  logic flag_v;
  logic [IW-1:0] flag_i;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [7:0] at [N];
  logic [PW-1:0] pl [N];
  int ord [N];
  int m_cnt;

  always #2 clk = ~clk;

  vec_pkt_reorder #(.N_ENTRIES(N), .PAYLOAD_W(PW)) i_vec_pkt_reorder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disas_only_i(disas), .count_i(count),
    .vec_i(vec_v), .load_i(ld_v), .store_i(st_v), .newval_i(nv_v), .tmp_i(tmp_v),
    .scat_rel_i(sr_v), .four_slot_i(four_v), .endloop_i(el_v), .payload_i(pl_in),
    .done_o(done), .payload_o(pl_out), .src_idx_o(src_out),
    .flag_valid_o(flag_v), .flag_idx_o(flag_i));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void mv(input int f, input int t);
    int tmp;
    if (f < t) begin
      tmp = ord[f];
      for (int k = f; k < t; k++) ord[k] = ord[k+1];
      ord[t] = tmp;
    end
  endfunction

  function automatic int tgt();
    int l = m_cnt - 1;
    return at[ord[l]][A_EL] ? l - 1 : l;
  endfunction

  task automatic run_pkt(input logic [31:0] attrs, input int cnt, input bit dis, input string tag);
    int ld, mx, i, fexp;
    logic [N*IW-1:0] exp_src, hold_src;
    logic [N*PW-1:0] exp_pl, hold_pl;
    int wait_n;
    for (int k = 0; k < N; k++) begin
      at[k] = attrs[8*k +: 8];
      rng = nxt(rng);
      pl[k] = rng[7:0];
      ord[k] = k;
    end
    m_cnt = cnt;
    if (!dis) begin
      ld = -1;
      for (int k = 0; k < cnt; k++)
        if (ld < 0 && at[ord[k]][A_LD] && (at[ord[k]][A_NV] || at[ord[k]][A_TMP])) ld = k;
      if (ld >= 0) begin
        mx = ld; i = 0;
        while (i < mx) begin
          if (at[ord[i]][A_VEC]) begin mv(i, tgt()); mx--; end
          else i++;
        end
      end
      for (int j = 0; j < cnt - 1; j++)
        if (at[ord[j]][A_ST] && at[ord[j]][A_NV] && !at[ord[j]][A_SR]) begin mv(j, tgt()); break; end
    end
    fexp = -1;
    for (int k = 0; k < cnt; k++) if (fexp < 0 && at[ord[k]][A_VEC] && at[ord[k]][A_FOUR]) fexp = k;
    for (int k = 0; k < N; k++) begin
      exp_src[k*IW +: IW] = IW'(ord[k]);
      exp_pl[k*PW +: PW]  = pl[ord[k]];
    end

    @(negedge clk);
    for (int k = 0; k < N; k++) begin
      vec_v[k] = at[k][A_VEC]; ld_v[k] = at[k][A_LD]; st_v[k] = at[k][A_ST]; nv_v[k] = at[k][A_NV];
      tmp_v[k] = at[k][A_TMP]; sr_v[k] = at[k][A_SR]; four_v[k] = at[k][A_FOUR]; el_v[k] = at[k][A_EL];
      pl_in[k*PW +: PW] = pl[k];
    end
    count = CW'(cnt); disas = dis; start = 1;
    @(negedge clk);
    start = 0;
    wait_n = 0;
    while (!done && wait_n < 20) begin @(negedge clk); wait_n++; end
    chk("R8 done within bound", 64'(done), 64'd1);
    chk(tag, 64'(src_out), 64'(exp_src));
    chk("R7 payload follows entry", 64'(pl_out), 64'(exp_pl));
    chk("R6 flag valid", 64'(flag_v), 64'(fexp >= 0));
    if (fexp >= 0) chk("R6 flag index", 64'(flag_i), 64'(fexp));
    hold_src = src_out; hold_pl = pl_out;
    @(negedge clk);
    chk("R8 done single pulse", 64'(done), 64'd0);
    chk("R8 outputs hold", {32'(hold_src), 32'(hold_pl)}, {32'(src_out), 32'(pl_out)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset flag", 64'(flag_v), 64'd0);
    chk("R1 reset order", 64'(src_out), 64'h E4);
    rst_n = 1;
    @(negedge clk);
    chk("R1 order after release", 64'(src_out), 64'h E4);

    // R2: vec, scalar, vec, vector new-value load
    run_pkt(32'hD0_80_00_80, 4, 0, "R2 pass one moves");
    // R2: two adjacent vector producers (same index re-examined)
    run_pkt(32'h00_48_80_80, 4, 0, "R2 adjacent moves");
    // R3: end-of-loop last pins target
    run_pkt(32'h01_48_80_80, 4, 0, "R3 endloop pinned");
    // R4: new-value store first, scatter-release store skipped
    run_pkt(32'h00_00_34_30, 3, 0, "R4 store moved");
    run_pkt(32'h00_00_30_34, 3, 0, "R4 scatter release skipped");
    // R4: only candidate in last position is excluded
    run_pkt(32'h00_30_00_80, 3, 0, "R4 last position excluded");
    // R4: two candidates, only the first moves
    run_pkt(32'h00_30_30_00, 4, 0, "R4 single move");
    // R5: disassembly mode keeps order
    run_pkt(32'hD0_80_00_80, 4, 1, "R5 disas bypass");
    // R6: four-slot on non-vector ignored, vector one flagged
    run_pkt(32'h00_82_02_00, 4, 1, "R6 flag order");
    // R7: entries beyond count untouched
    run_pkt(32'h80_D0_80_80, 2, 0, "R7 beyond count");

    for (int t = 0; t < 4000; t++) begin
      logic [31:0] a;
      int c;
      bit d;
      rng = nxt(rng); a = rng;
      rng = nxt(rng); c = 1 + int'(rng[1:0]);
      d = (rng[4:2] == 3'd0);
      run_pkt(a, c, d, d ? "R5 sweep order" : "R2 sweep order");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule